// File: doc/BRIEF.md
# Addressable LED Pulse Encoder

This block drives the single data wire of a daisy-chained string of addressable RGB LED drivers. It only transmits. Each driver in the chain keeps the first colour word it sees and passes the rest of the stream on to the next driver. The host delivers one 24-bit colour word per LED on a valid/ready stream. It flags the final LED of a frame with `in_last`.

Every bit takes a fixed slot. The line is high at the start of the slot, and the length of that high pulse tells a one from a zero. The drivers misread bits whose pulses drift, so all timing comes from cycle counts. These counts are derived at elaboration from the clock frequency and the nanosecond parameters. A one-word holding register lets the next word wait behind the one being sent, so slots follow each other without gaps.

When the final word of a frame is done, the line stays low for a long latch interval. The chain then shows the colours it loaded. If a frame runs dry before its last word, the encoder raises a one-cycle underrun pulse, keeps the line low and goes through the same latch interval.

Top module: `led_pulse_encoder`

## Requirements
- R1: After reset, `led_out` is 0, `underrun` is 0 and `in_ready` is 1.
- R2: A one bit is a high pulse of exactly T1H_NS worth of clock cycles (160 at 200 MHz), followed by low for the rest of its slot.
- R3: A zero bit is a high pulse of exactly T0H_NS worth of clock cycles (80 at 200 MHz), followed by low for the rest of its slot.
- R4: Each word is sent from `in_color[23]` down to `in_color[0]`. Green sits in bits 23:16, red in 15:8 and blue in 7:0. Words leave in the order they were accepted.
- R5: Within a frame, consecutive bit slots start exactly BIT_NS worth of cycles apart (250 at 200 MHz). This also holds across word boundaries, as long as the next word is offered while the current word is still being sent.
- R6: `in_ready` is 1 only while the holding register is empty and no word with `in_last` has been accepted in the current frame. It is 0 in the cycle after any accepted word.
- R7: After the last bit slot of a word accepted with `in_last`, the line stays low and `in_ready` stays 0 for at least RESET_NS worth of cycles (10000 at 200 MHz). After that, a new frame can start.
- R8: If a word without `in_last` finishes and no word is held, `underrun` is 1 for exactly one cycle while the line is low. The line then stays low and `in_ready` stays 0 for the latch interval.
- R9: No high pulse on `led_out` is longer than the one-bit high time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, frequency CLK_MHZ |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Colour word offered |
| in_ready | output | 1 | Encoder takes the offered word at this edge |
| in_color | input | 24 | Colour word: green 23:16, red 15:8, blue 7:0 |
| in_last | input | 1 | Offered word is the final LED of the frame |
| led_out | output | 1 | Serial data line to the LED chain |
| underrun | output | 1 | One-cycle pulse when a frame runs dry |

## Verification
Faults in the slot counter show up on the very next pulse. The measured high width or the rise-to-rise distance is off in the first bit that follows. A wrong bit index or shift register gives a wrong decoded word after 24 slots. A wrong holding-register flag shows up either as a lost or duplicated word at the decode step, or as a rise-to-rise gap inside a frame. Latch-state faults show up within one latch interval: `in_ready` returns too early, or the underrun pulse is missing or repeated.

// File: rtl/led_enc_pkg.sv
package led_enc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SEND  = 2'd1,
    ST_LATCH = 2'd2
  } enc_state_t;

  // Round a nanosecond span up to whole clock cycles.
  function automatic int ns_to_cycles(input int clk_mhz, input int span_ns);
    return (clk_mhz * span_ns + 999) / 1000;
  endfunction

endpackage

// File: rtl/led_slot_timer.sv
module led_slot_timer #(
  parameter int BIT_CYC = 250,
  parameter int T0H_CYC = 80,
  parameter int T1H_CYC = 160
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic bit_val,
  output logic slot_end,
  output logic drive_hi
);
  localparam int CW = $clog2(BIT_CYC);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run)
      cnt <= '0;
    else if (cnt == CW'(BIT_CYC - 1))
      cnt <= '0;
    else
      cnt <= cnt + 1'b1;
  end

  assign slot_end = run && (cnt == CW'(BIT_CYC - 1));
  assign drive_hi = run && (cnt < (bit_val ? CW'(T1H_CYC) : CW'(T0H_CYC)));

endmodule

// File: rtl/led_word_shift.sv
module led_word_shift #(
  parameter int WORD_W = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [WORD_W-1:0] load_word,
  input  logic              shift,
  output logic              msb,
  output logic              last_bit
);
  localparam int IW = $clog2(WORD_W);

  logic [WORD_W-1:0] sreg;
  logic [IW-1:0]     idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      sreg <= '0;
      idx  <= '0;
    end else if (load) begin
      sreg <= load_word;
      idx  <= '0;
    end else if (shift) begin
      sreg <= {sreg[WORD_W-2:0], 1'b0};
      idx  <= idx + 1'b1;
    end
  end

  assign msb      = sreg[WORD_W-1];
  assign last_bit = (idx == IW'(WORD_W - 1));

endmodule

// File: rtl/led_latch_timer.sv
module led_latch_timer #(
  parameter int RESET_CYC = 10000
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic done
);
  localparam int LW = $clog2(RESET_CYC + 1);

  logic [LW-1:0] cnt;
  logic          busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      busy <= 1'b0;
    end else if (start) begin
      cnt  <= LW'(RESET_CYC - 1);
      busy <= 1'b1;
    end else if (busy) begin
      if (cnt == '0)
        busy <= 1'b0;
      else
        cnt <= cnt - 1'b1;
    end
  end

  assign done = busy && (cnt == '0);

endmodule

// File: rtl/led_pulse_encoder.sv
module led_pulse_encoder
  import led_enc_pkg::*;
#(
  parameter int CLK_MHZ  = 200,
  parameter int T0H_NS   = 400,
  parameter int T1H_NS   = 800,
  parameter int BIT_NS   = 1250,
  parameter int RESET_NS = 50000,
  parameter int WORD_W   = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_color,
  input  logic              in_last,
  output logic              led_out,
  output logic              underrun
);
  localparam int T0H_CYC   = ns_to_cycles(CLK_MHZ, T0H_NS);
  localparam int T1H_CYC   = ns_to_cycles(CLK_MHZ, T1H_NS);
  localparam int BIT_CYC   = ns_to_cycles(CLK_MHZ, BIT_NS);
  localparam int RESET_CYC = ns_to_cycles(CLK_MHZ, RESET_NS);

  enc_state_t        state;
  logic              hold_full, hold_last, cur_last, frame_closed;
  logic [WORD_W-1:0] hold_word;
  logic              slot_end, drive_hi, msb, last_bit, lat_done;
  logic              accept, word_end, load, go_latch, dry;

  assign in_ready = !hold_full && !frame_closed && (state != ST_LATCH);
  assign accept   = in_valid && in_ready;
  assign word_end = slot_end && last_bit;
  assign dry      = word_end && !cur_last && !hold_full;
  assign go_latch = word_end && (cur_last || !hold_full);
  assign load     = ((state == ST_IDLE) && hold_full) ||
                    (word_end && !cur_last && hold_full);

  led_slot_timer #(
    .BIT_CYC(BIT_CYC), .T0H_CYC(T0H_CYC), .T1H_CYC(T1H_CYC)
  ) u_slot (
    .clk(clk), .rst(rst), .run(state == ST_SEND), .bit_val(msb),
    .slot_end(slot_end), .drive_hi(drive_hi)
  );

  led_word_shift #(.WORD_W(WORD_W)) u_shift (
    .clk(clk), .rst(rst), .load(load), .load_word(hold_word),
    .shift(slot_end && !last_bit), .msb(msb), .last_bit(last_bit)
  );

  led_latch_timer #(.RESET_CYC(RESET_CYC)) u_latch (
    .clk(clk), .rst(rst), .start(go_latch), .done(lat_done)
  );

  // Holding register: one word waits behind the one on the wire.
  always_ff @(posedge clk) begin
    if (rst) begin
      hold_full <= 1'b0;
      hold_last <= 1'b0;
      hold_word <= '0;
    end else if (load) begin
      hold_full <= 1'b0;
    end else if (accept) begin
      hold_full <= 1'b1;
      hold_last <= in_last;
      hold_word <= in_color;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_IDLE;
      cur_last     <= 1'b0;
      frame_closed <= 1'b0;
      led_out      <= 1'b0;
      underrun     <= 1'b0;
    end else begin
      led_out  <= drive_hi;
      underrun <= dry;
      if (load)
        cur_last <= hold_last;
      if (accept && in_last)
        frame_closed <= 1'b1;
      else if (lat_done)
        frame_closed <= 1'b0;
      case (state)
        ST_IDLE:  if (load) state <= ST_SEND;
        ST_SEND:  if (go_latch) state <= ST_LATCH;
        ST_LATCH: if (lat_done) state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/led_pulse_encoder_chk.sv
module led_pulse_encoder_chk
  import led_enc_pkg::*;
#(
  parameter int CLK_MHZ = 200,
  parameter int T1H_NS  = 800
) (
  input logic clk,
  input logic rst,
  input logic in_valid,
  input logic in_ready,
  input logic in_last,
  input logic led_out,
  input logic underrun
);
  localparam int T1H_CYC = ns_to_cycles(CLK_MHZ, T1H_NS);

  int hi_run;

  always_ff @(posedge clk) begin
    if (rst)
      hi_run <= 0;
    else if (led_out)
      hi_run <= hi_run + 1;
    else
      hi_run <= 0;
  end

  // R9
  pulse_width_chk: assert property (@(posedge clk) disable iff (rst)
    led_out |-> hi_run < T1H_CYC);

  // R8
  underrun_low_chk: assert property (@(posedge clk) disable iff (rst)
    underrun |-> !led_out);

  // R8
  underrun_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    underrun |=> !underrun);

  // R8
  underrun_block_chk: assert property (@(posedge clk) disable iff (rst)
    underrun |=> !in_ready);

  // R6
  hold_full_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> !in_ready);

  // R7
  frame_close_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && in_last) |=> !in_ready);

endmodule

bind led_pulse_encoder led_pulse_encoder_chk #(
  .CLK_MHZ(CLK_MHZ), .T1H_NS(T1H_NS)
) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .in_last(in_last), .led_out(led_out), .underrun(underrun)
);

// File: tb/led_pulse_encoder_tb.sv
`timescale 1ns/1ps
module led_pulse_encoder_tb;
  localparam int T0H_CYC   = 200 * 400 / 1000;
  localparam int T1H_CYC   = 200 * 800 / 1000;
  localparam int BIT_CYC   = 200 * 1250 / 1000;
  localparam int RESET_CYC = 200 * 50000 / 1000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic in_last = 1'b0;
  logic [23:0] in_color = '0;
  logic in_ready, led_out, underrun;

  always #2.5 clk = ~clk;

  led_pulse_encoder u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_color(in_color), .in_last(in_last), .led_out(led_out),
    .underrun(underrun)
  );

  int n_chk = 0, n_fail = 0;
  int cyc = 0;
  bit done = 0;
  logic [23:0] exp_q[$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int hi_len_for(input bit b);
    return b ? T1H_CYC : T0H_CYC;
  endfunction

  // Line monitor: pulse widths, slot spacing and word decoding.
  bit prev = 0;
  int hi_len = 0, rise_cyc = -1, last_fall_cyc = 0, ur_cyc = 0, ur_count = 0;
  int nb = 0;
  logic [23:0] rx_word = '0;

  always @(negedge clk) begin
    if (!rst) begin
      if (led_out && !prev) begin
        if (rise_cyc >= 0) begin
          if (cyc - rise_cyc < RESET_CYC)
            chk(cyc - rise_cyc == BIT_CYC, "R5 slot spacing", cyc - rise_cyc, BIT_CYC);
          else
            chk(1'b1, "R7 frame gap", cyc - rise_cyc, RESET_CYC);
        end
        rise_cyc = cyc;
        hi_len = 1;
      end else if (led_out) begin
        hi_len++;
      end
      if (!led_out && prev) begin
        bit b;
        last_fall_cyc = cyc;
        b = (hi_len == T1H_CYC);
        chk(hi_len == hi_len_for(b), "R2 R3 high width", hi_len, hi_len_for(b));
        rx_word = {rx_word[22:0], b};
        nb++;
        if (nb == 24) begin
          nb = 0;
          if (exp_q.size() > 0) begin
            chk(rx_word == exp_q[0], "R4 word content", int'(rx_word), int'(exp_q[0]));
            void'(exp_q.pop_front());
          end else begin
            chk(1'b0, "R4 unexpected word", int'(rx_word), 0);
          end
        end
      end
      prev = led_out;
      if (underrun) begin
        ur_count++;
        ur_cyc = cyc;
      end
    end
  end

  task automatic send_word(input logic [23:0] c, input bit last, input int gap);
    repeat (gap) @(negedge clk);
    in_valid = 1'b1;
    in_color = c;
    in_last  = last;
    while (!in_ready) @(negedge clk);
    exp_q.push_back(c);
    @(negedge clk);
    in_valid = 1'b0;
    in_last  = 1'b0;
    chk(!in_ready, "R6 ready drops after accept", int'(in_ready), 0);
  endtask

  task automatic wait_frame_gap();
    while (!in_ready) @(negedge clk);
    chk(cyc - last_fall_cyc >= RESET_CYC, "R7 latch interval", cyc - last_fall_cyc, RESET_CYC);
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(led_out == 1'b0, "R1 led_out", int'(led_out), 0);
    chk(in_ready == 1'b1, "R1 in_ready", int'(in_ready), 1);
    chk(underrun == 1'b0, "R1 underrun", int'(underrun), 0);

    // Directed: all ones, all zeros, mixed pattern in one frame.
    send_word(24'hFFFFFF, 1'b0, 0);
    send_word(24'h000000, 1'b0, 3);
    send_word(24'hA53C0F, 1'b1, 0);
    wait_frame_gap();
    chk(ur_count == 0, "R8 no underrun on full frame", ur_count, 0);

    // Directed underrun: single word without in_last, then nothing.
    send_word(24'h5A0081, 1'b0, 0);
    while (ur_count == 0) @(negedge clk);
    chk(led_out == 1'b0, "R8 line low at underrun", int'(led_out), 0);
    chk(in_ready == 1'b0, "R8 ready low at underrun", int'(in_ready), 0);
    while (!in_ready) @(negedge clk);
    chk(cyc - ur_cyc >= RESET_CYC, "R8 latch after underrun", cyc - ur_cyc, RESET_CYC);

    // Random frames of 1 or 2 words.
    for (int f = 0; f < 4; f++) begin
      int n = 1 + int'($urandom_range(1, 0));
      for (int w = 0; w < n; w++)
        send_word(24'($urandom), w == n - 1, int'($urandom_range(40, 0)));
      wait_frame_gap();
    end

    repeat (2 * BIT_CYC) @(negedge clk);
    chk(exp_q.size() == 0, "R4 all words sent", exp_q.size(), 0);
    chk(ur_count == 1, "R8 underrun count", ur_count, 1);
    chk(led_out == 1'b0, "R7 idle line low", int'(led_out), 0);

    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule